// File: doc/BRIEF.md
# Link Backpressure Sender

This block sits on the upstream end of one router-to-router link. It decides, flit by flit, whether the flit offered by the local source may go onto the link. It supports three flow-control schemes behind a single interface. In credit mode it counts the free slots in the downstream buffer. In on/off mode it obeys a single permission bit. In ack/nack mode it keeps no view of downstream space: it sends one flit, keeps a copy, and sends it again on a negative reply or when no reply arrives in time.

The scheme is chosen by a two-bit mode input that may change only while reset is asserted. A companion receiver model, `link_bp_rx_stub`, holds the downstream buffer and produces the return signals from its occupancy. It returns credits on buffer pops, drives the permission bit with a high/low threshold pair, and answers each arriving flit with an ack or a nack. Accepted flits leave the sender one cycle after the source handshake, through a registered link output.

Top module: `link_bp_sender`

## Requirements
- R1: After reset the link output is idle, the overflow flag is clear, credit mode offers `src_ready` high (count equal to DEPTH), no flit is outstanding, and the receiver model reports an empty buffer with the permission bit high.
- R2: In credit mode `src_ready` is high exactly when the credit count is non-zero. Each accepted flit lowers the count by one and appears on `tx_valid`/`tx_flit` in the following cycle. Each `credit_ret` pulse raises the count by one.
- R3: In credit mode, a credit pulse that arrives in the same cycle as an accepted flit leaves the count unchanged.
- R4: In credit mode, a credit pulse that arrives while the count equals DEPTH, with no send in that cycle, sets `credit_err`. The count stays at DEPTH, and `credit_err` stays high until reset.
- R5: In on/off mode `src_ready` follows `xon` in the same cycle, and no flit goes onto the link while `xon` is low.
- R6: The receiver model drives its permission bit low in the cycle after its occupancy is at or above HI. It drives the bit high in the cycle after its occupancy is at or below LO. Between the two thresholds it keeps its previous value.
- R7: In credit mode the receiver model raises `credit_ret` for one cycle in the cycle after each buffer pop.
- R8: In ack/nack mode at most one flit is outstanding. `src_ready` is low from the cycle after an accept until the cycle after an `ack`, and the link carries only the held flit in that interval.
- R9: In ack/nack mode, a `nack` while a flit is outstanding puts the held flit back onto the link in the next cycle.
- R10: In ack/nack mode, with no reply, the held flit is sent again TIMEOUT cycles after its previous transmission. An `ack` in the cycle the timer expires takes priority and suppresses the resend.
- R11: In ack/nack mode the receiver model answers each arriving flit one cycle later: an `ack` if the flit was stored, or a `nack` if the buffer was full, in which case the flit is discarded.
- R12: With the sender and the receiver model connected, flits are delivered in the order they were accepted, with no loss or duplication, in every mode. In ack/nack mode this holds even when flits are lost on the link.
- R13: Mode encoding: 0 selects credit, 1 selects on/off, 2 selects ack/nack, and 3 behaves as credit. The mode is held constant outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Flow-control scheme select, static outside reset |
| src_valid | input | 1 | Source offers a flit |
| src_flit | input | FLIT_W | Flit offered by the source |
| src_ready | output | 1 | Sender accepts the offered flit this cycle |
| tx_valid | output | 1 | Flit present on the link |
| tx_flit | output | FLIT_W | Flit driven onto the link |
| credit_ret | input | 1 | One returned credit (credit mode) |
| xon | input | 1 | Permission to send (on/off mode) |
| ack | input | 1 | Positive reply for the outstanding flit |
| nack | input | 1 | Negative reply for the outstanding flit |
| credit_err | output | 1 | Sticky credit overflow flag |

## Verification
The assertions assume the following about the block's inputs:
- The mode is not changed outside reset.
- The receiver's buffer depth equals the credit count's reset value.
- The on/off high threshold leaves at least two free slots for flits already in flight.
- Any reply arrives well before the timeout.
- No stray `ack` or `nack` arrives.

The stimulus keeps to these assumptions. It changes the mode only under reset and builds the sender and receiver from the same depth. In ack/nack mode it loses only forward flits, never replies. Spurious credits are injected on purpose only in the directed overflow case, where the sender's response to them is what is under test.

// File: rtl/link_bp_pkg.sv
package link_bp_pkg;

    typedef enum logic [1:0] {
        FC_CREDIT  = 2'd0,
        FC_ONOFF   = 2'd1,
        FC_ACKNACK = 2'd2,
        FC_RSVD    = 2'd3
    } fc_mode_e;

endpackage

// File: rtl/link_bp_credit.sv
module link_bp_credit #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic send,
    input  logic credit,
    output logic has_credit,
    output logic err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
    } cred_st_t;

    cred_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable) begin
            case ({send, credit})
                2'b10: st_d.cnt = st_q.cnt - 1'b1;
                2'b01: begin
                    if (st_q.cnt == FULL) st_d.err = 1'b1;
                    else                  st_d.cnt = st_q.cnt + 1'b1;
                end
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= FULL;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign has_credit = (st_q.cnt != '0);
    assign err        = st_q.err;

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL); // R4
    AST_NO_SEND_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        enable && send |-> st_q.cnt != '0); // R2
    AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        enable && send && credit |=> $stable(st_q.cnt)); // R3
    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        enable && credit && !send && st_q.cnt == FULL |=> st_q.err); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err); // R4

endmodule

// File: rtl/link_bp_retx.sv
module link_bp_retx #(
    parameter int FLIT_W  = 16,
    parameter int TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              src_valid,
    input  logic [FLIT_W-1:0] src_flit,
    input  logic              ack,
    input  logic              nack,
    output logic              busy,
    output logic              launch,
    output logic [FLIT_W-1:0] launch_flit
);
    localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 2;
    localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

    typedef struct packed {
        logic              busy;
        logic [FLIT_W-1:0] hold;
        logic [TW-1:0]     timer;
    } retx_st_t;

    retx_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        launch      = 1'b0;
        launch_flit = st_q.hold;
        if (enable && src_valid && !st_q.busy) begin
            st_d.busy   = 1'b1;
            st_d.hold   = src_flit;
            st_d.timer  = '0;
            launch      = 1'b1;
            launch_flit = src_flit;
        end else if (st_q.busy) begin
            if (ack) begin
                st_d.busy = 1'b0;
            end else if (nack || st_q.timer == TLAST) begin
                launch     = 1'b1;
                st_d.timer = '0;
            end else begin
                st_d.timer = st_q.timer + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && $past(st_q.busy) |-> $stable(st_q.hold)); // R8
    AST_NACK_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && nack && !ack |-> launch && launch_flit == st_q.hold); // R9
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.timer <= TLAST); // R10
    AST_ACK_NO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && ack |-> !launch); // R10

endmodule

// File: rtl/link_bp_rx_stub.sv
module link_bp_rx_stub #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 8,
    parameter int HI     = 5,
    parameter int LO     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              lk_valid,
    input  logic [FLIT_W-1:0] lk_flit,
    input  logic              rx_pop,
    output logic              rx_valid,
    output logic [FLIT_W-1:0] rx_flit,
    output logic              credit_ret,
    output logic              xon,
    output logic              ack,
    output logic              nack
);
    import link_bp_pkg::*;

    localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);
    localparam logic [OW-1:0] FULL = OW'(DEPTH);
    localparam logic [OW-1:0] HI_C = OW'(HI);
    localparam logic [OW-1:0] LO_C = OW'(LO);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][FLIT_W-1:0] mem;
        logic [PW-1:0]                wr;
        logic [PW-1:0]                rd;
        logic [OW-1:0]                occ;
        logic                         credit;
        logic                         xon;
        logic                         ack;
        logic                         nack;
    } stub_st_t;

    stub_st_t st_d, st_q;
    fc_mode_e fc;
    logic     is_ack, is_credit, full, push, popf;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PLAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fc        = fc_mode_e'(mode);
        is_ack    = (fc == FC_ACKNACK);
        is_credit = (fc != FC_ACKNACK) && (fc != FC_ONOFF);
        full      = (st_q.occ == FULL);
        push      = lk_valid && (!is_ack || !full);
        popf      = rx_pop && (st_q.occ != '0);

        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = lk_flit;
            st_d.wr           = wrap_inc(st_q.wr);
        end
        if (popf) st_d.rd = wrap_inc(st_q.rd);
        st_d.occ    = st_q.occ + OW'(push) - OW'(popf);
        st_d.credit = is_credit && popf;
        st_d.ack    = is_ack && lk_valid && !full;
        st_d.nack   = is_ack && lk_valid && full;
        if (st_q.occ >= HI_C)      st_d.xon = 1'b0;
        else if (st_q.occ <= LO_C) st_d.xon = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.xon <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid   = (st_q.occ != '0);
    assign rx_flit    = st_q.mem[st_q.rd];
    assign credit_ret = st_q.credit;
    assign xon        = st_q.xon;
    assign ack        = st_q.ack;
    assign nack       = st_q.nack;

    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !is_ack |-> !full); // R12
    AST_XON_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ >= HI_C |=> !st_q.xon); // R6
    AST_XON_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= LO_C |=> st_q.xon); // R6
    AST_REPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ack && st_q.nack)); // R11

endmodule

// File: rtl/link_bp_sender.sv
module link_bp_sender #(
    parameter int FLIT_W  = 16,
    parameter int DEPTH   = 8,
    parameter int TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              src_valid,
    input  logic [FLIT_W-1:0] src_flit,
    output logic              src_ready,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              credit_ret,
    input  logic              xon,
    input  logic              ack,
    input  logic              nack,
    output logic              credit_err
);
    import link_bp_pkg::*;

    typedef struct packed {
        logic              tx_valid;
        logic [FLIT_W-1:0] tx_flit;
    } tx_st_t;

    tx_st_t            st_d, st_q;
    fc_mode_e          fc;
    logic              is_ack, is_onoff, is_credit, accept;
    logic              has_credit, busy, launch;
    logic [FLIT_W-1:0] launch_flit;

    assign fc        = fc_mode_e'(mode);
    assign is_ack    = (fc == FC_ACKNACK);
    assign is_onoff  = (fc == FC_ONOFF);
    assign is_credit = !is_ack && !is_onoff;

    link_bp_credit #(.DEPTH(DEPTH)) i_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (is_credit),
        .send       (is_credit && accept),
        .credit     (credit_ret),
        .has_credit (has_credit),
        .err        (credit_err)
    );

    link_bp_retx #(.FLIT_W(FLIT_W), .TIMEOUT(TIMEOUT)) i_retx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (is_ack),
        .src_valid   (src_valid),
        .src_flit    (src_flit),
        .ack         (ack),
        .nack        (nack),
        .busy        (busy),
        .launch      (launch),
        .launch_flit (launch_flit)
    );

    always_comb begin
        if (is_ack)        src_ready = !busy;
        else if (is_onoff) src_ready = xon;
        else               src_ready = has_credit;
        accept = src_valid && src_ready;

        st_d = st_q;
        if (is_ack) begin
            st_d.tx_valid = launch;
            if (launch) st_d.tx_flit = launch_flit;
        end else begin
            st_d.tx_valid = accept;
            if (accept) st_d.tx_flit = src_flit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.tx_valid;
    assign tx_flit  = st_q.tx_flit;

    AST_MODE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode)); // R13
    AST_TX_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ack && accept |=> tx_valid && tx_flit == $past(src_flit)); // R2
    AST_ONOFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        is_onoff && !xon |-> !src_ready); // R5
    AST_TX_ONLY_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack && tx_valid |-> busy); // R8

endmodule

// File: tb/test_link_bp_sender.sv
`timescale 1ns/1ps
module test_link_bp_sender;
    localparam int FW = 16;
    localparam int DEPTH = 8;
    localparam int TO = 8;
    localparam int HI = 5;
    localparam int LO = 2;
    localparam logic [1:0] M_CREDIT = 2'd0, M_ONOFF = 2'd1, M_ACK = 2'd2, M_RSVD = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = M_CREDIT;
    logic src_valid = 1'b0;
    logic [FW-1:0] src_flit = '0;
    logic src_ready, tx_valid, credit_err;
    logic [FW-1:0] tx_flit;
    logic own = 1'b1, drop = 1'b0;
    logic b_credit = 1'b0, b_xon = 1'b0, b_ack = 1'b0, b_nack = 1'b0;
    logic s_credit, s_xon, s_ack, s_nack;
    logic rx_pop = 1'b0, rx_valid;
    logic [FW-1:0] rx_flit;
    logic credit_in, xon_in, ack_in, nack_in, lk_valid;

    int checks = 0;
    int errors = 0;
    logic [FW-1:0] sb [0:4095];
    int head, tail;

    always #4 clk = ~clk;

    assign credit_in = own ? b_credit : s_credit;
    assign xon_in    = own ? b_xon    : s_xon;
    assign ack_in    = own ? b_ack    : s_ack;
    assign nack_in   = own ? b_nack   : s_nack;
    assign lk_valid  = tx_valid && !own && !drop;

    link_bp_sender #(.FLIT_W(FW), .DEPTH(DEPTH), .TIMEOUT(TO)) i_link_bp_sender (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .src_valid(src_valid), .src_flit(src_flit), .src_ready(src_ready),
        .tx_valid(tx_valid), .tx_flit(tx_flit),
        .credit_ret(credit_in), .xon(xon_in), .ack(ack_in), .nack(nack_in),
        .credit_err(credit_err)
    );

    link_bp_rx_stub #(.FLIT_W(FW), .DEPTH(DEPTH), .HI(HI), .LO(LO)) i_stub (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .lk_valid(lk_valid), .lk_flit(tx_flit),
        .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_flit(rx_flit),
        .credit_ret(s_credit), .xon(s_xon), .ack(s_ack), .nack(s_nack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit next_xon(input int occ, input bit cur);
        if (occ >= HI) return 1'b0;
        if (occ <= LO) return 1'b1;
        return cur;
    endfunction

    task automatic do_reset(input logic [1:0] m, input bit bench_owns);
        @(negedge clk);
        rst_n = 1'b0;
        mode = m;
        own = bench_owns;
        drop = 1'b0;
        src_valid = 1'b0; src_flit = '0; rx_pop = 1'b0;
        b_credit = 1'b0; b_xon = 1'b0; b_ack = 1'b0; b_nack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_credit();
        do_reset(M_CREDIT, 1'b1);
        chk(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
        chk(tx_valid == 1'b0, "R1 link idle", tx_valid, 0);
        chk(credit_err == 1'b0, "R1 error clear", credit_err, 0);
        chk(rx_valid == 1'b0, "R1 stub empty", rx_valid, 0);
        chk(s_xon == 1'b1, "R1 stub permission", s_xon, 1);
        src_valid = 1'b1; src_flit = 16'hA000;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk(tx_valid && tx_flit == FW'(16'hA000 + i), "R2 flit on link", tx_flit, 16'hA000 + i);
            if (i < DEPTH - 1) src_flit = FW'(16'hA000 + i + 1);
            else src_valid = 1'b0;
        end
        chk(src_ready == 1'b0, "R2 ready low at zero credits", src_ready, 0);
        b_credit = 1'b1;
        @(negedge clk);
        b_credit = 1'b0;
        chk(src_ready == 1'b1, "R2 credit restores ready", src_ready, 1);
        src_valid = 1'b1; b_credit = 1'b1; src_flit = 16'hA0F0;
        @(negedge clk);
        src_valid = 1'b0; b_credit = 1'b0;
        chk(tx_valid == 1'b1, "R3 send with credit", tx_valid, 1);
        chk(src_ready == 1'b1, "R3 count unchanged", src_ready, 1);
        src_valid = 1'b1;
        @(negedge clk);
        src_valid = 1'b0;
        chk(src_ready == 1'b0, "R3 count was one", src_ready, 0);
        b_credit = 1'b1;
        repeat (DEPTH) @(negedge clk);
        chk(credit_err == 1'b0, "R4 no error at full", credit_err, 0);
        @(negedge clk);
        b_credit = 1'b0;
        chk(credit_err == 1'b1, "R4 overflow flagged", credit_err, 1);
        src_valid = 1'b1;
        repeat (DEPTH) @(negedge clk);
        src_valid = 1'b0;
        chk(src_ready == 1'b0, "R4 count clamped at DEPTH", src_ready, 0);
        chk(credit_err == 1'b1, "R4 error sticky", credit_err, 1);
    endtask

    task automatic test_rsvd();
        do_reset(M_RSVD, 1'b1);
        src_valid = 1'b1;
        repeat (DEPTH) @(negedge clk);
        src_valid = 1'b0;
        chk(src_ready == 1'b0, "R13 mode 3 counts credits", src_ready, 0);
    endtask

    task automatic test_onoff();
        do_reset(M_ONOFF, 1'b1);
        src_valid = 1'b1; src_flit = 16'hC001;
        #1;
        chk(src_ready == 1'b0, "R5 ready follows xon low", src_ready, 0);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R5 nothing sent while off", tx_valid, 0);
        b_xon = 1'b1;
        #1;
        chk(src_ready == 1'b1, "R5 ready follows xon high", src_ready, 1);
        @(negedge clk);
        src_valid = 1'b0;
        chk(tx_valid && tx_flit == 16'hC001, "R5 sent when on", tx_flit, 16'hC001);
    endtask

    task automatic test_acknack();
        do_reset(M_ACK, 1'b1);
        chk(src_ready == 1'b1, "R8 idle ready", src_ready, 1);
        src_valid = 1'b1; src_flit = 16'hB001;
        @(negedge clk);
        src_valid = 1'b0;
        chk(tx_valid && tx_flit == 16'hB001, "R8 first send", tx_flit, 16'hB001);
        chk(src_ready == 1'b0, "R8 one outstanding", src_ready, 0);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R8 no extra send", tx_valid, 0);
        b_nack = 1'b1;
        @(negedge clk);
        b_nack = 1'b0;
        chk(tx_valid && tx_flit == 16'hB001, "R9 resend after nack", tx_flit, 16'hB001);
        for (int k = 1; k < TO; k++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R10 quiet before timeout", tx_valid, 0);
        end
        @(negedge clk);
        chk(tx_valid && tx_flit == 16'hB001, "R10 resend on timeout", tx_flit, 16'hB001);
        for (int k = 1; k < TO; k++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R10 quiet before timeout", tx_valid, 0);
        end
        b_ack = 1'b1;
        @(negedge clk);
        b_ack = 1'b0;
        chk(tx_valid == 1'b0, "R10 ack beats timeout", tx_valid, 0);
        chk(src_ready == 1'b1, "R8 ready after ack", src_ready, 1);
    endtask

    task automatic run_loop(input logic [1:0] m, input int cycles);
        int m_occ;
        bit exp_xon, exp_cr, exp_ack, exp_nack, pf, link;
        do_reset(m, 1'b0);
        head = 0; tail = 0; m_occ = 0;
        exp_xon = 1'b1; exp_cr = 1'b0; exp_ack = 1'b0; exp_nack = 1'b0;
        for (int cyc = 0; cyc < cycles + 400; cyc++) begin
            @(negedge clk);
            chk(s_xon == exp_xon, "R6 permission hysteresis", s_xon, exp_xon);
            if (m == M_CREDIT) chk(s_credit == exp_cr, "R7 credit after pop", s_credit, exp_cr);
            if (m == M_ACK) begin
                chk(s_ack == exp_ack, "R11 ack", s_ack, exp_ack);
                chk(s_nack == exp_nack, "R11 nack", s_nack, exp_nack);
            end
            chk(rx_valid == (m_occ != 0), "R12 occupancy", rx_valid, m_occ != 0);
            if (cyc < cycles) begin
                src_valid = ($urandom % 4) != 0;
                src_flit = FW'($urandom);
                if (cyc < cycles / 2) rx_pop = ($urandom % 4) == 0;
                else rx_pop = ($urandom % 4) != 0;
            end else begin
                src_valid = 1'b0;
                rx_pop = 1'b1;
            end
            drop = (m == M_ACK) && (($urandom % 6) == 0);
            #1;
            if (src_valid && src_ready) begin
                sb[tail] = src_flit;
                tail++;
            end
            pf = rx_pop && rx_valid;
            if (pf) begin
                chk(head < tail, "R12 no extra flit", head, tail);
                chk(rx_flit == sb[head], "R12 in-order delivery", rx_flit, sb[head]);
                head++;
            end
            link = tx_valid && !drop;
            exp_xon  = next_xon(m_occ, exp_xon);
            exp_cr   = (m == M_CREDIT) && pf;
            exp_ack  = (m == M_ACK) && link && (m_occ < DEPTH);
            exp_nack = (m == M_ACK) && link && (m_occ == DEPTH);
            m_occ = m_occ + ((link && (m != M_ACK || m_occ < DEPTH)) ? 1 : 0) - (pf ? 1 : 0);
        end
        src_valid = 1'b0; rx_pop = 1'b0; drop = 1'b0;
        chk(head == tail, "R12 all flits delivered", head, tail);
        chk(tail > 100, "R12 traffic volume", tail, 100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        test_credit();
        test_rsvd();
        test_onoff();
        test_acknack();
        run_loop(M_CREDIT, 3000);
        run_loop(M_ONOFF, 3000);
        run_loop(M_ACK, 3000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule